// File: doc/BRIEF.md
# NAND Flash Cycle Strobe Sequencer

This block turns single bus-cycle requests into correctly timed NAND-style pin activity. Each request names a cycle type (command, address, data read or data write), selects one of two timing sets (common space or attribute space) and carries one data word. The block asserts chip enable, raises the command latch or address latch line as the cycle type requires, and walks through a setup phase, a strobe phase and a hold phase. The strobe phase drives the read strobe for reads and the write strobe for all other cycle types. Each timing set programs four durations: setup, strobe, hold and, for data writes, an initial high-impedance window on the data bus.

When a read directly follows a command cycle or an address cycle, the read's setup phase is stretched to a separately programmed minimum gap. This gives the latch-line-low to read-strobe-low delays a device needs. If the wait feature is enabled, a low ready/busy input holds the strobe phase open. A one-cycle done pulse closes every access and carries the captured read data.

Requests use valid/ready. A request must stay stable while `req_valid` is high and `req_ready` is low. `req_ready` is high only while the block is idle, so only one access is in flight at a time. The done pulse `rsp_valid` has no back-pressure and lasts exactly one cycle.

Top module: `nfc_strobe_timer`

## Requirements
- R1: After reset `nand_ce_n`, `nand_re_n` and `nand_we_n` are 1, `nand_cle`, `nand_ale`, `dq_oe` and `rsp_valid` are 0, and `req_ready` is 1.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from that edge until the cycle after the done pulse. `nand_ce_n` is 0 in every setup, strobe and hold cycle.
- R3: `req_kind` encodes 0 = command, 1 = address, 2 = data read, 3 = data write. `nand_cle` is 1 throughout a command access and `nand_ale` is 1 throughout an address access. Neither line is 1 for data accesses, and neither is 1 while `nand_ce_n` is 1.
- R4: The strobe phase drives `nand_re_n` low for reads and `nand_we_n` low for the other three cycle types. The two strobes are never low together.
- R5: The timing-set fields are bits [7:0] setup, [15:8] strobe, [23:16] hold and [31:24] high-impedance. The setup phase lasts exactly the setup value in cycles, and 0 skips it.
- R6: With the wait feature off, the strobe phase lasts the strobe value in cycles, or one cycle when that value is 0.
- R7: The hold phase lasts exactly the hold value in cycles. It is followed by one cycle with `rsp_valid` = 1 and `nand_ce_n` = 1.
- R8: For data writes, `dq_oe` stays 0 for the first N active cycles, where N is the high-impedance value. It is then 1 for the rest of the access, with `dq_out` equal to the request data. Command and address accesses drive the bus in every active cycle. Reads never drive it.
- R9: `req_space` = 0 selects `cfg_common_tim` and 1 selects `cfg_attr_tim`, per request.
- R10: A read that follows a completed command access has setup length max(setup, `cfg_cle_gap`). A read that follows an address access uses max(setup, `cfg_ale_gap`).
- R11: With `wait_en` = 1, a strobe phase whose programmed count has elapsed stays asserted while `nand_rb` is 0. With `wait_en` = 0, `nand_rb` has no effect on the strobe length.
- R12: On a read, `dq_in` is captured at the edge that ends the strobe phase and presented on `rsp_data` during the done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block idle, request accepted this edge if valid |
| req_kind | input | 2 | Cycle type: 0 command, 1 address, 2 read, 3 write |
| req_space | input | 1 | Timing set: 0 common, 1 attribute |
| req_data | input | DW | Command, address or write data word |
| cfg_common_tim | input | 4*TW | Common-space setup/strobe/hold/high-impedance durations |
| cfg_attr_tim | input | 4*TW | Attribute-space durations, same layout |
| cfg_cle_gap | input | TW | Minimum setup of a read after a command access |
| cfg_ale_gap | input | TW | Minimum setup of a read after an address access |
| wait_en | input | 1 | Let ready/busy stretch the strobe phase |
| nand_rb | input | 1 | Device ready (1) / busy (0) |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_we_n | output | 1 | Write strobe, active low |
| dq_out | output | DW | Data bus output value |
| dq_oe | output | 1 | Data bus output enable |
| dq_in | input | DW | Data bus input value |
| rsp_valid | output | 1 | One-cycle done pulse |
| rsp_data | output | DW | Read data captured at strobe end |

## Verification
The checker watches properties that hold on every cycle:
- the two strobes are never low together, and the latch lines are never high together;
- no strobe, latch line or bus drive is active outside chip enable;
- `req_ready` is low during an access;
- the done pulse lasts exactly one cycle with chip enable released;
- a busy device with the wait feature on keeps the strobe low across the edge.

The exact phase lengths cannot be seen cycle by cycle from the pins. Only the bench's measured sweeps can show them: setup, strobe, hold and high-impedance lengths across both timing sets, the read-gap stretch after command and address accesses, wait extension against a disabled wait feature, and read data capture.

// File: rtl/nfc_pkg.sv
package nfc_pkg;
  typedef enum logic [1:0] {
    KIND_CMD   = 2'd0,
    KIND_ADDR  = 2'd1,
    KIND_READ  = 2'd2,
    KIND_WRITE = 2'd3
  } nfc_kind_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD,
    PH_DONE
  } nfc_phase_e;

  // field index inside a packed timing set
  localparam int FLD_SETUP  = 0;
  localparam int FLD_STROBE = 1;
  localparam int FLD_HOLD   = 2;
  localparam int FLD_HIZ    = 3;
  localparam int NUM_FLD    = 4;
endpackage

// File: rtl/nfc_tim_sel.sv
module nfc_tim_sel
  import nfc_pkg::*;
#(
  parameter int TW = 8
) (
  input  logic                    space,
  input  nfc_kind_e               kind,
  input  logic                    prev_valid,
  input  nfc_kind_e               prev_kind,
  input  logic [NUM_FLD*TW-1:0]   cfg_common,
  input  logic [NUM_FLD*TW-1:0]   cfg_attr,
  input  logic [TW-1:0]           cle_gap,
  input  logic [TW-1:0]           ale_gap,
  output logic [TW-1:0]           setup_len,
  output logic [TW-1:0]           strobe_len,
  output logic [TW-1:0]           hold_len,
  output logic [TW-1:0]           hiz_len
);
  logic [TW-1:0] sel [NUM_FLD];
  logic [TW-1:0] gap;

  for (genvar f = 0; f < NUM_FLD; f++) begin : g_field
    assign sel[f] = space ? cfg_attr[f*TW +: TW] : cfg_common[f*TW +: TW];
  end

  always_comb begin
    gap = '0;
    if (kind == KIND_READ && prev_valid) begin
      if (prev_kind == KIND_CMD)       gap = cle_gap;
      else if (prev_kind == KIND_ADDR) gap = ale_gap;
    end
  end

  assign setup_len  = (gap > sel[FLD_SETUP]) ? gap : sel[FLD_SETUP];
  assign strobe_len = (sel[FLD_STROBE] == '0) ? TW'(1) : sel[FLD_STROBE];
  assign hold_len   = sel[FLD_HOLD];
  assign hiz_len    = sel[FLD_HIZ];
endmodule

// File: rtl/nfc_phase_seq.sv
module nfc_phase_seq
  import nfc_pkg::*;
#(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [TW-1:0] setup_len,
  input  logic [TW-1:0] strobe_len,
  input  logic [TW-1:0] hold_len,
  input  logic          wait_en,
  input  logic          rb,
  output nfc_phase_e    phase,
  output logic          strobe_end
);
  logic [TW-1:0] cnt;
  logic [TW-1:0] strobe_r;
  logic [TW-1:0] hold_r;
  logic          stall;

  assign stall      = wait_en && !rb;
  assign strobe_end = (phase == PH_STROBE) && (cnt == '0) && !stall;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      strobe_r <= '0;
      hold_r   <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: if (start) begin
          strobe_r <= strobe_len;
          hold_r   <= hold_len;
          if (setup_len != '0) begin
            phase <= PH_SETUP;
            cnt   <= setup_len - 1'b1;
          end else begin
            phase <= PH_STROBE;
            cnt   <= strobe_len - 1'b1;
          end
        end
        PH_SETUP: begin
          if (cnt == '0) begin
            phase <= PH_STROBE;
            cnt   <= strobe_r - 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_STROBE: begin
          if (strobe_end) begin
            if (hold_r != '0) begin
              phase <= PH_HOLD;
              cnt   <= hold_r - 1'b1;
            end else begin
              phase <= PH_DONE;
            end
          end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_HOLD: begin
          if (cnt == '0) phase <= PH_DONE;
          else           cnt   <= cnt - 1'b1;
        end
        PH_DONE: phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nfc_strobe_timer.sv
module nfc_strobe_timer
  import nfc_pkg::*;
#(
  parameter int DW = 8,
  parameter int TW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [1:0]      req_kind,
  input  logic            req_space,
  input  logic [DW-1:0]   req_data,
  input  logic [4*TW-1:0] cfg_common_tim,
  input  logic [4*TW-1:0] cfg_attr_tim,
  input  logic [TW-1:0]   cfg_cle_gap,
  input  logic [TW-1:0]   cfg_ale_gap,
  input  logic            wait_en,
  input  logic            nand_rb,
  output logic            nand_ce_n,
  output logic            nand_cle,
  output logic            nand_ale,
  output logic            nand_re_n,
  output logic            nand_we_n,
  output logic [DW-1:0]   dq_out,
  output logic            dq_oe,
  input  logic [DW-1:0]   dq_in,
  output logic            rsp_valid,
  output logic [DW-1:0]   rsp_data
);
  nfc_phase_e    phase;
  nfc_kind_e     kind_r;
  nfc_kind_e     prev_kind;
  logic          prev_valid;
  logic [DW-1:0] data_r;
  logic [TW-1:0] hz_cnt;
  logic [TW-1:0] setup_len, strobe_len, hold_len, hiz_len;
  logic          strobe_end;
  logic          accept;
  logic          active;

  assign req_ready = (phase == PH_IDLE);
  assign accept    = req_valid && req_ready;
  assign active    = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);

  nfc_tim_sel #(.TW(TW)) u_sel (
    .space      (req_space),
    .kind       (nfc_kind_e'(req_kind)),
    .prev_valid (prev_valid),
    .prev_kind  (prev_kind),
    .cfg_common (cfg_common_tim),
    .cfg_attr   (cfg_attr_tim),
    .cle_gap    (cfg_cle_gap),
    .ale_gap    (cfg_ale_gap),
    .setup_len  (setup_len),
    .strobe_len (strobe_len),
    .hold_len   (hold_len),
    .hiz_len    (hiz_len)
  );

  nfc_phase_seq #(.TW(TW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (accept),
    .setup_len  (setup_len),
    .strobe_len (strobe_len),
    .hold_len   (hold_len),
    .wait_en    (wait_en),
    .rb         (nand_rb),
    .phase      (phase),
    .strobe_end (strobe_end)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kind_r     <= KIND_CMD;
      data_r     <= '0;
      hz_cnt     <= '0;
      prev_valid <= 1'b0;
      prev_kind  <= KIND_CMD;
      rsp_data   <= '0;
    end else begin
      if (accept) begin
        kind_r <= nfc_kind_e'(req_kind);
        data_r <= req_data;
        hz_cnt <= hiz_len;
      end else if (active && hz_cnt != '0) begin
        hz_cnt <= hz_cnt - 1'b1;
      end
      if (strobe_end && kind_r == KIND_READ) rsp_data <= dq_in;
      if (phase == PH_DONE) begin
        prev_valid <= 1'b1;
        prev_kind  <= kind_r;
      end
    end
  end

  assign nand_ce_n = !active;
  assign nand_cle  = active && (kind_r == KIND_CMD);
  assign nand_ale  = active && (kind_r == KIND_ADDR);
  assign nand_re_n = !((phase == PH_STROBE) && (kind_r == KIND_READ));
  assign nand_we_n = !((phase == PH_STROBE) && (kind_r != KIND_READ));
  assign dq_out    = data_r;
  assign dq_oe     = active && (kind_r != KIND_READ) &&
                     ((kind_r != KIND_WRITE) || (hz_cnt == '0));
  assign rsp_valid = (phase == PH_DONE);
endmodule

// File: rtl/nfc_strobe_checker.sv
module nfc_strobe_checker #(
  parameter int DW = 8,
  parameter int TW = 8
) (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic wait_en,
  input logic nand_rb,
  input logic nand_ce_n,
  input logic nand_cle,
  input logic nand_ale,
  input logic nand_re_n,
  input logic nand_we_n,
  input logic dq_oe,
  input logic rsp_valid
);
  // R4: strobes mutually exclusive
  p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_re_n && !nand_we_n));

  // R3: latch lines exclusive and only inside chip enable
  p_latch_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));
  p_latch_in_ce_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (nand_cle || nand_ale || !nand_re_n || !nand_we_n) |-> !nand_ce_n);

  // R2: no new request accepted during an access
  p_busy_not_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_ce_n |-> !req_ready);

  // R7: done is a single cycle with chip enable released
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  p_done_ce_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> nand_ce_n);

  // R8: bus is driven only inside an access
  p_oe_in_ce_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> !nand_ce_n);

  // R11: a busy device keeps the strobe low
  p_wait_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((!nand_re_n || !nand_we_n) && wait_en && !nand_rb) |=> (!nand_re_n || !nand_we_n));
endmodule

bind nfc_strobe_timer nfc_strobe_checker #(.DW(DW), .TW(TW)) u_chk (.*);

// File: tb/tb_nfc_strobe_timer.sv
module tb_nfc_strobe_timer;
  localparam int DW = 8;
  localparam int TW = 8;

  logic clk = 0;
  logic rst_n = 0;
  logic req_valid = 0;
  logic req_ready;
  logic [1:0] req_kind = 0;
  logic req_space = 0;
  logic [DW-1:0] req_data = 0;
  logic [TW-1:0] cs = 0, ca = 0, ch = 0, cz = 0;
  logic [TW-1:0] as_ = 0, aa = 0, ah = 0, az = 0;
  logic [TW-1:0] tclr = 0, tar = 0;
  logic wait_en = 0;
  logic nand_rb = 1;
  logic nand_ce_n, nand_cle, nand_ale, nand_re_n, nand_we_n, dq_oe, rsp_valid;
  logic [DW-1:0] dq_out, rsp_data;
  logic [DW-1:0] dq_in = 0;
  logic [4*TW-1:0] cfg_common_tim, cfg_attr_tim;

  int nchk = 0;
  int nerr = 0;
  bit pv = 0;
  int pk = 0;

  assign cfg_common_tim = {cz, ch, ca, cs};
  assign cfg_attr_tim   = {az, ah, aa, as_};

  always #5 clk = ~clk;

  nfc_strobe_timer #(.DW(DW), .TW(TW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_space(req_space), .req_data(req_data),
    .cfg_common_tim(cfg_common_tim), .cfg_attr_tim(cfg_attr_tim),
    .cfg_cle_gap(tclr), .cfg_ale_gap(tar), .wait_en(wait_en), .nand_rb(nand_rb),
    .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_re_n(nand_re_n), .nand_we_n(nand_we_n), .dq_out(dq_out), .dq_oe(dq_oe),
    .dq_in(dq_in), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  // one access; busy = strobe cycles during which the device reports busy
  task automatic xfer(int k, int sp, int d, int busy);
    int s, a, h, z, gap, exp_s, exp_a, exp_h, tot;
    int n_set, n_str, n_hold, n_hz, guard;
    bit seen_str, oe_seen, oe_drop, bad_strobe, bad_latch, bad_dq, bad_ready, done;
    s = sp ? as_ : cs; a = sp ? aa : ca; h = sp ? ah : ch; z = sp ? az : cz;
    gap = 0;
    if (k == 2 && pv) gap = (pk == 0) ? tclr : (pk == 1) ? tar : 0;
    exp_s = imax(s, gap);
    exp_a = imax(a, 1);
    if (wait_en) exp_a = imax(exp_a, busy + 1);
    exp_h = h;
    tot = exp_s + exp_a + exp_h;
    n_set = 0; n_str = 0; n_hold = 0; n_hz = 0; guard = 0;
    seen_str = 0; oe_seen = 0; oe_drop = 0; done = 0;
    bad_strobe = 0; bad_latch = 0; bad_dq = 0; bad_ready = 0;

    @(negedge clk);
    req_valid = 1; req_kind = 2'(k); req_space = sp[0]; req_data = DW'(d);
    dq_in = DW'(d ^ 8'h5A);
    chk("R2 ready before accept", int'(req_ready), 1);
    @(negedge clk);
    req_valid = 0;
    while (!done && guard < 3000) begin
      guard++;
      if (rsp_valid) begin
        done = 1;
        chk("R7 ce released at done", int'(nand_ce_n), 1);
        if (k == 2) chk("R12 read data", int'(rsp_data), (d ^ 8'h5A) & 8'hFF);
      end else begin
        if (nand_ce_n || req_ready) bad_ready = 1;
        if (nand_cle != (k == 0) || nand_ale != (k == 1)) bad_latch = 1;
        if (!nand_re_n || !nand_we_n) begin
          seen_str = 1;
          n_str++;
          if ((k == 2) ? (nand_re_n || !nand_we_n) : (!nand_re_n || nand_we_n)) bad_strobe = 1;
          nand_rb = (n_str <= busy) ? 1'b0 : 1'b1;
        end else if (!seen_str) n_set++;
        else n_hold++;
        if (dq_oe) begin
          oe_seen = 1;
          if (dq_out != DW'(d)) bad_dq = 1;
        end else begin
          if (oe_seen) oe_drop = 1;
          else n_hz++;
        end
        @(negedge clk);
      end
    end
    nand_rb = 1;
    if (!done) begin
      nerr++;
      $display("FAIL R7 access never completed actual=0 expected=1");
    end
    chk("R2 ce low and ready low during access", int'(bad_ready), 0);
    chk("R3 latch lines per kind", int'(bad_latch), 0);
    chk("R4 strobe selection", int'(bad_strobe), 0);
    chk((k == 2 && gap > 0) ? "R10 read gap setup" : "R5 R9 setup length", n_set, exp_s);
    chk((busy > 0) ? "R11 wait strobe length" : "R6 strobe length", n_str, exp_a);
    chk("R7 hold length", n_hold, exp_h);
    if (k == 3)      chk("R8 write high-z cycles", n_hz, (z < tot) ? z : tot);
    else if (k == 2) chk("R8 read never drives", n_hz, tot);
    else             chk("R8 cmd/addr drive all cycles", n_hz, 0);
    chk("R8 bus drive continuous and data", int'(oe_drop | bad_dq), 0);
    pv = 1; pk = k;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", nerr, nchk + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ce_n", int'(nand_ce_n), 1);
    chk("R1 re_n", int'(nand_re_n), 1);
    chk("R1 we_n", int'(nand_we_n), 1);
    chk("R1 cle/ale", int'(nand_cle | nand_ale), 0);
    chk("R1 oe/done", int'(dq_oe | rsp_valid), 0);
    chk("R1 ready", int'(req_ready), 1);
    rst_n = 1;

    // sweep common space, attribute set kept distinct (R5 R6 R7 R8)
    as_ = 9; aa = 7; ah = 8; az = 9;
    for (int s = 0; s <= 2; s++)
      for (int a = 0; a <= 2; a++)
        for (int h = 0; h <= 2; h++)
          for (int z = 0; z <= 6; z += 3)
            for (int k = 0; k < 4; k++) begin
              cs = TW'(s); ca = TW'(a); ch = TW'(h); cz = TW'(z);
              xfer(k, 0, 16 * s + 4 * a + h + k + z, 0);
            end

    // R9 attribute space selection
    cs = 1; ca = 1; ch = 1; cz = 1;
    as_ = 3; aa = 4; ah = 2; az = 5;
    for (int k = 0; k < 4; k++) xfer(k, 1, 8'hA0 + k, 0);
    az = 20;
    xfer(3, 1, 8'h77, 0);

    // R10 latch-low to read-strobe gaps
    tclr = 4; tar = 6; cs = 2; ca = 1; ch = 1; cz = 0;
    xfer(0, 0, 8'h30, 0); xfer(2, 0, 8'h31, 0);
    xfer(1, 0, 8'h32, 0); xfer(2, 0, 8'h33, 0);
    xfer(3, 0, 8'h34, 0); xfer(2, 0, 8'h35, 0);
    cs = 7;
    xfer(0, 0, 8'h36, 0); xfer(2, 0, 8'h37, 0);
    tclr = 0; tar = 0;

    // R11 wait extension, and ready/busy ignored when disabled
    cs = 1; ch = 1;
    wait_en = 1;
    for (int a = 1; a <= 3; a += 2)
      for (int b = 0; b <= 5; b++)
        for (int k = 2; k <= 3; k++) begin
          ca = TW'(a);
          xfer(k, 0, 8'h40 + 8 * b + a + k, b);
        end
    wait_en = 0;
    ca = 2;
    xfer(2, 0, 8'h61, 4);
    xfer(3, 0, 8'h62, 4);

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule